// File: doc/BRIEF.md
# Scaled-Index Address Generator

This block forms a 64-bit effective address out of up to three terms: a base register value, an index register value scaled by a power of two, and a signed 32-bit displacement. Three low bits of a 4-bit minor opcode each switch one term on or off, so a single adder tree serves every address form. These forms include base only, scaled index only, displacement only and every combination of them. The same sum is used either as a register result (the load-effective-address family) or as the memory address for register-indirect and displacement loads and stores.

The scale field is a shift amount, not a multiplier. Codes 0 to 3 shift the index left by 0 to 3 places. Any larger code is flagged as illegal, and the index then enters the sum unshifted. All arithmetic wraps at 64 bits and gives no overflow indication. A parameter selects whether the result leaves through an output register or straight from the adder.

Top module: `agen_top`

## Requirements
- R1: Bit 0 of `minor_op` enables the base term, bit 1 the scaled-index term and bit 2 the displacement term. Bit 3 has no effect on any output, so codes 9 and 13 give the same results as codes 1 and 5.
- R2: When `scale_code` holds a value from 0 to 3, the index term equals `index_val` shifted left by that many places (x1, x2, x4, x8). Bits shifted beyond bit 63 are lost.
- R3: The address is the sum of the enabled terms modulo 2^64. There is no carry-out or overflow output.
- R4: `imm_val` is a two's-complement 32-bit value and is sign-extended to 64 bits before it is added.
- R5: `scale_illegal` is 1 exactly when the index term is enabled and `scale_code` is greater than 3. In that case the index enters the sum unshifted. In every other case `scale_illegal` is 0.
- R6: A disabled term contributes zero, whatever value is present on its input.
- R7: With `OUT_REG`=1 (the default), `addr_out` and `scale_illegal` reflect the inputs sampled at the previous rising edge of `clk`. While `rst` is high at an edge, both are cleared to 0.
- R8: When `minor_op[2:0]` is 0, `addr_out` is 0 and `scale_illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when OUT_REG=1) |
| rst | input | 1 | Synchronous active-high reset of the output register |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| scale_code | input | 4 | Left-shift amount applied to the index |
| imm_val | input | 32 | Signed displacement |
| minor_op | input | 4 | Term-enable code: bit0 base, bit1 index, bit2 displacement |
| addr_out | output | 64 | Effective address |
| scale_illegal | output | 1 | Scale code above 3 with the index enabled |

## Verification
In the default registered build, both the address and the illegal flag are due exactly one rising edge after the inputs are applied. The bench changes the inputs on a falling edge, lets one rising edge capture them, and compares both outputs on the following falling edge. An expected-value queue, filled when each stimulus is applied and emptied one per cycle, keeps every comparison aligned to that single-cycle delay. The bench also checks the reset state, and it checks that an input that was changing during reset never reaches the outputs.

// File: rtl/agen_pkg.sv
package agen_pkg;

    localparam int ADDR_BITS  = 64;
    localparam int DISP_BITS  = 32;
    localparam int SHIFT_BITS = 4;
    localparam int CODE_BITS  = 4;
    localparam int MAX_SHIFT  = 3;
    localparam int NUM_TERMS  = 3;

    typedef enum int {
        TERM_BASE  = 0,
        TERM_INDEX = 1,
        TERM_DISP  = 2
    } term_id_e;

    typedef struct packed {
        logic disp;
        logic index;
        logic base;
    } term_en_t;

    function automatic term_en_t decode_terms(input logic [CODE_BITS-1:0] code);
        term_en_t en;
        en.base  = code[0];
        en.index = code[1];
        en.disp  = code[2];
        return en;
    endfunction

    function automatic logic shift_is_legal(input logic [SHIFT_BITS-1:0] sc);
        return (int'(sc) <= MAX_SHIFT);
    endfunction

endpackage

// File: rtl/agen_scale.sv
module agen_scale
    import agen_pkg::*;
#(
    parameter int DATA_W  = ADDR_BITS,
    parameter int SCALE_W = SHIFT_BITS
) (
    input  logic [DATA_W-1:0]  index_in,
    input  logic [SCALE_W-1:0] shift_code,
    input  logic               index_on,
    output logic [DATA_W-1:0]  scaled_out,
    output logic               bad_shift
);

    localparam int NSTEPS = MAX_SHIFT + 1;

    logic [DATA_W-1:0] shifted [NSTEPS];
    logic              legal;

    genvar g;
    generate
        for (g = 0; g < NSTEPS; g++) begin : g_step
            assign shifted[g] = index_in << g;
        end
    endgenerate

    always_comb begin
        legal      = shift_is_legal(shift_code);
        scaled_out = index_in;
        for (int k = 0; k < NSTEPS; k++) begin
            if (legal && int'(shift_code) == k) scaled_out = shifted[k];
        end
        bad_shift = index_on && !legal;
    end

endmodule

// File: rtl/agen_terms.sv
module agen_terms
    import agen_pkg::*;
#(
    parameter int DATA_W = ADDR_BITS,
    parameter int IMM_W  = DISP_BITS
) (
    input  logic [DATA_W-1:0] base_in,
    input  logic [DATA_W-1:0] scaled_in,
    input  logic [IMM_W-1:0]  disp_in,
    input  term_en_t          enables,
    output logic [DATA_W-1:0] operands [NUM_TERMS]
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] raw   [NUM_TERMS];
    logic              on    [NUM_TERMS];

    assign raw[TERM_BASE]  = base_in;
    assign raw[TERM_INDEX] = scaled_in;
    assign raw[TERM_DISP]  = {{EXT_W{disp_in[IMM_W-1]}}, disp_in};

    assign on[TERM_BASE]   = enables.base;
    assign on[TERM_INDEX]  = enables.index;
    assign on[TERM_DISP]   = enables.disp;

    genvar t;
    generate
        for (t = 0; t < NUM_TERMS; t++) begin : g_gate
            assign operands[t] = on[t] ? raw[t] : '0;
        end
    endgenerate

endmodule

// File: rtl/agen_sum.sv
module agen_sum
    import agen_pkg::*;
#(
    parameter int DATA_W = ADDR_BITS,
    parameter int N_IN   = NUM_TERMS
) (
    input  logic [DATA_W-1:0] terms [N_IN],
    output logic [DATA_W-1:0] total
);

    always_comb begin
        total = '0;
        for (int k = 0; k < N_IN; k++) begin
            total = total + terms[k];
        end
    end

endmodule

// File: rtl/agen_top.sv
module agen_top
    import agen_pkg::*;
#(
    parameter int DATA_W  = ADDR_BITS,
    parameter int IMM_W   = DISP_BITS,
    parameter int SCALE_W = SHIFT_BITS,
    parameter int OP_W    = CODE_BITS,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  base_val,
    input  logic [DATA_W-1:0]  index_val,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic [IMM_W-1:0]   imm_val,
    input  logic [OP_W-1:0]    minor_op,
    output logic [DATA_W-1:0]  addr_out,
    output logic               scale_illegal
);

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic              illegal;
    } agen_res_t;

    term_en_t          en;
    logic [DATA_W-1:0] scaled;
    logic [DATA_W-1:0] ops [NUM_TERMS];
    agen_res_t         comb_res;
    agen_res_t         out_res;

    assign en = decode_terms(minor_op);

    agen_scale #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_scale (
        .index_in   (index_val),
        .shift_code (scale_code),
        .index_on   (en.index),
        .scaled_out (scaled),
        .bad_shift  (comb_res.illegal)
    );

    agen_terms #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_terms (
        .base_in   (base_val),
        .scaled_in (scaled),
        .disp_in   (imm_val),
        .enables   (en),
        .operands  (ops)
    );

    agen_sum #(.DATA_W(DATA_W), .N_IN(NUM_TERMS)) u_sum (
        .terms (ops),
        .total (comb_res.addr)
    );

    generate
        if (OUT_REG) begin : g_reg
            logic primed;

            always_ff @(posedge clk) begin
                if (rst) begin
                    out_res <= '0;
                    primed  <= 1'b0;
                end else begin
                    out_res <= comb_res;
                    primed  <= 1'b1;
                end
            end

            // R8: no terms selected gives zero
            p_zero_code_r8: assert property (@(posedge clk) disable iff (rst || !primed)
                ($past(minor_op[2:0]) == 3'b000) |-> (addr_out == '0 && !scale_illegal));

            // R1: base-only code passes the base through
            p_base_only_r1: assert property (@(posedge clk) disable iff (rst || !primed)
                ($past(minor_op[2:0]) == 3'b001) |-> (addr_out == $past(base_val)));

            // R4: displacement-only code yields the sign-extended immediate
            p_disp_sext_r4: assert property (@(posedge clk) disable iff (rst || !primed)
                ($past(minor_op[2:0]) == 3'b100) |->
                (addr_out == {{(DATA_W-IMM_W){$past(imm_val[IMM_W-1])}}, $past(imm_val)}));

            // R2: legal scale on index-only code shifts the index
            p_index_shift_r2: assert property (@(posedge clk) disable iff (rst || !primed)
                ($past(minor_op[2:0]) == 3'b010 && $past(scale_code) <= 4'd3) |->
                (addr_out == ($past(index_val) << $past(scale_code))));

            // R5: flag set only for an oversized scale on an enabled index
            p_bad_scale_r5: assert property (@(posedge clk) disable iff (rst || !primed)
                ($past(minor_op[1]) && $past(scale_code) > 4'd3) |-> scale_illegal);
            p_good_scale_r5: assert property (@(posedge clk) disable iff (rst || !primed)
                (!$past(minor_op[1]) || $past(scale_code) <= 4'd3) |-> !scale_illegal);

            // R7: reset clears the output register
            p_reset_clear_r7: assert property (@(posedge clk)
                $past(rst) |-> (addr_out == '0 && !scale_illegal));
        end else begin : g_comb
            assign out_res = comb_res;
        end
    endgenerate

    assign addr_out      = out_res.addr;
    assign scale_illegal = out_res.illegal;

endmodule

// File: tb/test_agen_top.sv
module test_agen_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] base_val  = '0;
    logic [63:0] index_val = '0;
    logic [3:0]  scale_code = '0;
    logic [31:0] imm_val   = '0;
    logic [3:0]  minor_op  = '0;
    logic [63:0] addr_out;
    logic        scale_illegal;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [63:0] addr;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t expq[$];

    always #4 clk = ~clk;

    agen_top i_agen_top (
        .clk           (clk),
        .rst           (rst),
        .base_val      (base_val),
        .index_val     (index_val),
        .scale_code    (scale_code),
        .imm_val       (imm_val),
        .minor_op      (minor_op),
        .addr_out      (addr_out),
        .scale_illegal (scale_illegal)
    );

    function automatic exp_t model(input logic [63:0] b, input logic [63:0] x,
                                   input logic [3:0] sc, input logic [31:0] im,
                                   input logic [3:0] op, input string tag);
        exp_t e;
        longint unsigned acc = 0;
        longint unsigned mult;
        e.ill = 1'b0;
        if (op[0]) acc += b;
        if (op[1]) begin
            if (sc < 4) mult = 64'd1 << sc;
            else begin
                mult  = 1;
                e.ill = 1'b1;
            end
            acc += x * mult;
        end
        if (op[2]) acc += longint'(signed'(im));
        e.addr = acc;
        e.tag  = tag;
        return e;
    endfunction

    task automatic check_out(input exp_t e);
        n_tests++;
        if (addr_out !== e.addr || scale_illegal !== e.ill) begin
            n_fail++;
            $display("FAIL %s: addr=%h ill=%b expected addr=%h ill=%b",
                     e.tag, addr_out, scale_illegal, e.addr, e.ill);
        end
    endtask

    task automatic drive(input logic [63:0] b, input logic [63:0] x, input logic [3:0] sc,
                         input logic [31:0] im, input logic [3:0] op, input string tag);
        base_val = b; index_val = x; scale_code = sc; imm_val = im; minor_op = op;
        expq.push_back(model(b, x, sc, im, op, tag));
        @(posedge clk);
        @(negedge clk);
        check_out(expq.pop_front());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R7: reset state, with busy inputs held during reset
        @(negedge clk);
        base_val = 64'hDEAD_BEEF_0000_1111; minor_op = 4'h7; scale_code = 4'hF;
        repeat (2) @(negedge clk);
        check_out('{addr: 64'h0, ill: 1'b0, tag: "R7 reset"});
        rst = 1'b0;

        // R8: nothing selected
        drive(64'h1234, 64'h5678, 4'd2, 32'h9, 4'h0, "R8 zero code");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 4'd9, 32'hFFFF_FFFF, 4'h8, "R8 zero code bit3");
        // R1 / R6: single terms, others loaded with junk
        drive(64'h0000_0000_0000_0030, 64'hAAAA, 4'd3, 32'h5555, 4'h1, "R1 base only");
        drive(64'h0000_0000_0000_0030, 64'hAAAA, 4'd3, 32'h5555, 4'h9, "R1 bit3 ignored");
        drive(64'hFFFF_0000_FFFF_0000, 64'h7, 4'd1, 32'h10, 4'h6, "R6 base absent");
        drive(64'h30, 64'h1, 4'd3, 32'h8000_0000, 4'h3, "R6 disp absent");
        // R2: each legal scale
        for (int s = 0; s < 4; s++)
            drive(64'h0, 64'h0000_0000_0000_0005, 4'(s), 32'h0, 4'h2, "R2 scale");
        drive(64'h30, 64'h1, 4'd3, 32'h0, 4'h3, "R2 base+index x8");
        drive(64'h0, 64'hF000_0000_0000_0001, 4'd3, 32'h0, 4'h2, "R2 shift drops top bits");
        // R4: sign extension
        drive(64'h0, 64'h0, 4'd0, 32'hFFFF_FFF8, 4'h4, "R4 negative disp");
        drive(64'h100, 64'h0, 4'd0, 32'hFFFF_FFF8, 4'h5, "R4 disp+base");
        drive(64'h100, 64'h0, 4'd0, 32'h7FFF_FFFF, 4'hD, "R4 positive disp bit3");
        // R3: wraparound
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 4'd0, 32'h1, 4'h7, "R3 wrap all terms");
        drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 4'd0, 32'h0, 4'h3, "R3 wrap to zero");
        // R5: illegal scale
        drive(64'h10, 64'h3, 4'd4, 32'h0, 4'h3, "R5 illegal with index");
        drive(64'h10, 64'h3, 4'd15, 32'h2, 4'h7, "R5 illegal code 15");
        drive(64'h10, 64'h3, 4'd15, 32'h2, 4'h5, "R5 no flag without index");
        // mixed patterns, all requirements
        for (int i = 0; i < 200; i++)
            drive({$urandom, $urandom}, {$urandom, $urandom}, 4'($urandom),
                  $urandom, 4'($urandom), "R1 R3 R5 mixed");
        // R7: reset mid-run clears the register
        base_val = 64'h55; minor_op = 4'h1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_out('{addr: 64'h0, ill: 1'b0, tag: "R7 reset mid-run"});
        rst = 1'b0;
        drive(64'h55, 64'h0, 4'd0, 32'h0, 4'h1, "R7 after reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule